// File: doc/BRIEF.md
# Serial Flash Boot Loader

This block reads a boot image out of a serial flash after reset, acting as a SPI master. It waits for an external init line to go from low to high. On that edge it samples a 3-bit mode strap and a 3-bit variant strap. When the mode strap selects serial-flash loading, it pulls chip select low and sends a read command with a start address. It then clocks in image bytes and presents each one on a parallel output together with a one-cycle valid strobe.

The serial clock starts slow. The first image byte carries a 2-bit rate field, and once that byte is complete the serial clock switches to the divider the field selects for the rest of the read. After a byte count has been received, taken from an input when loading starts, the loader releases chip select, parks the serial clock low and raises done. Pad pull-ups, tri-state control and image integrity checks are outside this block.

Top module: `cfg_flash_loader`

## Requirements
- R1: After reset cs_n_o is high, sclk_o is low, done_o is low and data_vld_o is low. init_i must be seen low after reset before a rising edge of init_i counts. At each rising edge of init_i while idle, mode_i and variant_i are sampled. Mode 3'b001 drives cs_n_o low on the next clock edge and starts loading. Any other mode leaves cs_n_o high and sclk_o low, and a later rising edge of init_i is sampled again.
- R2: Once loading has started, changes on mode_i, variant_i, byte_count_i and init_i do not alter the command sent, the data received or the number of bytes.
- R3: Variant 3'b111 sends a 40-bit header: command 0x0B, a 24-bit address of zero, then 8 zero dummy bits. Any other variant sends a 32-bit header: command 0x03, then the 24-bit zero address. Data capture begins at the sclk rising edge that follows the last header bit.
- R4: The header goes out on mosi_o most significant bit first. While cs_n_o stays low, mosi_o changes only on the clock edge at which sclk_o falls.
- R5: din_i is sampled on the clock edge at which sclk_o rises. Bits are assembled most significant first: the first bit of a byte lands in bit 7.
- R6: data_vld_o is high for exactly one clock per received byte, is raised on the edge at which sclk_o rises, and data_o holds that byte while it is high.
- R7: sclk_o idles low. Its initial period is 64 clocks, 32 high and 32 low.
- R8: Bits [1:0] of the first data byte select the sclk divider: 00 gives 64, 01 gives 16, 10 gives 8 and 11 gives 4. The new divider applies from the high phase after that byte's last rising edge until the end of the transfer.
- R9: byte_count_i is latched when loading starts, and a value of 0 is treated as 1. cs_n_o stays low from the start until the sclk falling edge after the last data bit. On that edge cs_n_o goes high, done_o goes high and sclk_o stays low from then on.
- R10: done_o stays high until reset, and later rising edges of init_i start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Init release; its rising edge samples the straps |
| mode_i | input | 3 | Mode strap; 3'b001 selects serial-flash loading |
| variant_i | input | 3 | Variant strap; 3'b111 selects the fast read header |
| byte_count_i | input | CNT_W (16) | Number of image bytes to read (0 acts as 1) |
| cs_n_o | output | 1 | Flash chip select, active low |
| sclk_o | output | 1 | Serial clock to the flash |
| mosi_o | output | 1 | Serial command and address to the flash |
| din_i | input | 1 | Serial data from the flash |
| data_o | output | 8 | Received byte |
| data_vld_o | output | 1 | One-clock strobe per received byte |
| done_o | output | 1 | Load finished |

## Verification
The chip select reacts one clock after the init edge is sampled. A byte strobe appears on the same clock edge as the sclk rise that carries the byte's last bit. Done follows on the next sclk fall, which is half a divided period later. The bench never counts these latencies by hand. It models the flash on the sclk_o and cs_n_o transitions themselves: header bits are captured at sclk rises, and din is changed at sclk falls, so it settles at least one half period before the design samples it. Strobes and port levels are sampled on the falling system clock edge. Sclk periods are measured in system clocks between successive rises, which checks the initial divider and the switched one directly.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_DATA,
      ST_TAIL,
      ST_DONE
   } ld_state_t;

   localparam logic [2:0] MODE_SERIAL = 3'b001;
   localparam logic [2:0] VARIANT_FAST = 3'b111;
endpackage

// File: rtl/cfgl_sclk_gen.sv
module cfgl_sclk_gen #(
   parameter int HALF_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [HALF_W-1:0] half_i,
   output logic              sclk_o,
   output logic              rise_o,
   output logic              fall_o
);
   logic [HALF_W-1:0] ph_q;
   logic              sclk_q;
   logic              flip;

   if (HALF_W < 2) begin : g_bad_w
      $error("cfgl_sclk_gen: HALF_W must be at least 2");
   end

   assign flip   = run_i && (ph_q >= half_i - 1'b1);
   assign rise_o = flip && !sclk_q;
   assign fall_o = flip && sclk_q;
   assign sclk_o = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= '0;
         sclk_q <= 1'b0;
      end else if (!run_i) begin
         ph_q   <= '0;
         sclk_q <= 1'b0;
      end else if (flip) begin
         ph_q   <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end
endmodule

// File: rtl/cfgl_serializer.sv
module cfgl_serializer #(
   parameter int W = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] word_i,
   input  logic         shift_i,
   output logic         bit_o
);
   logic [W-1:0] sreg_q;

   if (W < 2) begin : g_bad_w
      $error("cfgl_serializer: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sreg_q <= '0;
      else if (load_i)  sreg_q <= word_i;
      else if (shift_i) sreg_q <= {sreg_q[W-2:0], 1'b0};
   end

   assign bit_o = sreg_q[W-1];
endmodule

// File: rtl/cfgl_deser.sv
module cfgl_deser #(
   parameter int W = 8,
   localparam int CW = $clog2(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         shift_i,
   input  logic         bit_i,
   output logic         last_o,
   output logic [W-1:0] word_nxt_o,
   output logic [W-1:0] word_o,
   output logic         vld_o
);
   logic [W-1:0]  sreg_q;
   logic [CW-1:0] cnt_q;

   if (W < 2) begin : g_bad_w
      $error("cfgl_deser: W must be at least 2");
   end

   assign word_nxt_o = {sreg_q[W-2:0], bit_i};
   assign last_o     = shift_i && (cnt_q == CW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         cnt_q  <= '0;
         word_o <= '0;
         vld_o  <= 1'b0;
      end else begin
         vld_o <= last_o;
         if (clr_i) begin
            cnt_q <= '0;
         end else if (shift_i) begin
            sreg_q <= word_nxt_o;
            cnt_q  <= last_o ? '0 : cnt_q + 1'b1;
         end
         if (last_o) word_o <= word_nxt_o;
      end
   end

   // R6: strobe never lasts two clocks
   a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> !vld_o);
endmodule

// File: rtl/cfg_flash_loader.sv
module cfg_flash_loader
   import cfgl_pkg::*;
#(
   parameter int              CNT_W       = 16,
   parameter int              ADDR_W      = 24,
   parameter logic [ADDR_W-1:0] START_ADDR = '0,
   parameter logic [7:0]      CMD_FAST    = 8'h0B,
   parameter logic [7:0]      CMD_STD     = 8'h03,
   parameter int              HALF_W      = 6,
   parameter int unsigned     RATE_DIV [4] = '{64, 16, 8, 4},
   parameter int              RATE_LSB    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic [2:0]       mode_i,
   input  logic [2:0]       variant_i,
   input  logic [CNT_W-1:0] byte_count_i,
   output logic             cs_n_o,
   output logic             sclk_o,
   output logic             mosi_o,
   input  logic             din_i,
   output logic [7:0]       data_o,
   output logic             data_vld_o,
   output logic             done_o
);
   localparam int HDR_W    = 8 + ADDR_W + 8;
   localparam int LEN_STD  = 8 + ADDR_W;
   localparam int HCNT_W   = $clog2(HDR_W + 1);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("cfg_flash_loader: CNT_W must be positive");
   end
   if (ADDR_W < 8 || ADDR_W % 8 != 0) begin : g_bad_addr
      $error("cfg_flash_loader: ADDR_W must be a whole number of bytes");
   end
   if (RATE_LSB < 0 || RATE_LSB > 6) begin : g_bad_lsb
      $error("cfg_flash_loader: rate field must lie inside the first byte");
   end

   // divider table: one half-period entry per rate code
   logic [HALF_W-1:0] half_tab [4];
   for (genvar g = 0; g < 4; g++) begin : g_rate
      if (RATE_DIV[g] < 4 || RATE_DIV[g] % 2 != 0 ||
          RATE_DIV[g] / 2 >= (2 ** HALF_W)) begin : g_bad_div
         $error("cfg_flash_loader: each divider must be even, >= 4 and fit HALF_W");
      end
      assign half_tab[g] = HALF_W'(RATE_DIV[g] / 2);
   end

   ld_state_t         st_q;
   logic              init_q;
   logic              init_rise;
   logic              start;
   logic              fast_sel;
   logic [HDR_W-1:0]  hdr_word;
   logic [HCNT_W-1:0] hdr_cnt_q, hdr_len_q;
   logic [CNT_W-1:0]  byte_idx_q, nbytes_q;
   logic [HALF_W-1:0] half_q;
   logic              run, rise, fall;
   logic              byte_last;
   logic [7:0]        byte_nxt;

   assign init_rise = init_i && !init_q;
   assign start     = (st_q == ST_IDLE) && init_rise && (mode_i == MODE_SERIAL);
   assign fast_sel  = (variant_i == VARIANT_FAST);
   assign hdr_word  = fast_sel ? {CMD_FAST, START_ADDR, 8'h00}
                               : {CMD_STD,  START_ADDR, 8'h00};
   assign run       = (st_q == ST_HDR) || (st_q == ST_DATA) || (st_q == ST_TAIL);

   cfgl_sclk_gen #(.HALF_W(HALF_W)) u_sclk (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (run),
      .half_i(half_q),
      .sclk_o(sclk_o),
      .rise_o(rise),
      .fall_o(fall)
   );

   cfgl_serializer #(.W(HDR_W)) u_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start),
      .word_i (hdr_word),
      .shift_i(fall),
      .bit_o  (mosi_o)
   );

   cfgl_deser #(.W(8)) u_des (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (start),
      .shift_i   (rise && (st_q == ST_DATA)),
      .bit_i     (din_i),
      .last_o    (byte_last),
      .word_nxt_o(byte_nxt),
      .word_o    (data_o),
      .vld_o     (data_vld_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         init_q     <= 1'b1;
         cs_n_o     <= 1'b1;
         done_o     <= 1'b0;
         hdr_cnt_q  <= '0;
         hdr_len_q  <= '0;
         byte_idx_q <= '0;
         nbytes_q   <= '0;
         half_q     <= half_tab[0];
      end else begin
         init_q <= init_i;
         case (st_q)
            ST_IDLE: if (start) begin
               st_q       <= ST_HDR;
               cs_n_o     <= 1'b0;
               hdr_cnt_q  <= '0;
               hdr_len_q  <= fast_sel ? HCNT_W'(HDR_W) : HCNT_W'(LEN_STD);
               byte_idx_q <= '0;
               nbytes_q   <= (byte_count_i == '0) ? CNT_W'(1) : byte_count_i;
               half_q     <= half_tab[0];
            end
            ST_HDR: if (rise) begin
               hdr_cnt_q <= hdr_cnt_q + 1'b1;
               if (hdr_cnt_q == hdr_len_q - 1'b1) st_q <= ST_DATA;
            end
            ST_DATA: if (byte_last) begin
               byte_idx_q <= byte_idx_q + 1'b1;
               if (byte_idx_q == '0) half_q <= half_tab[byte_nxt[RATE_LSB +: 2]];
               if (byte_idx_q == nbytes_q - 1'b1) st_q <= ST_TAIL;
            end
            ST_TAIL: if (fall) begin
               cs_n_o <= 1'b1;
               done_o <= 1'b1;
               st_q   <= ST_DONE;
            end
            default: ;
         endcase
      end
   end

   // R1: idle loader keeps the flash deselected and the clock parked
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> (cs_n_o && !sclk_o));
   // R4: mid-transfer MOSI moves only with a falling serial clock
   a_r4_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && !$past(cs_n_o) && (mosi_o != $past(mosi_o))) |-> (!sclk_o && $past(sclk_o)));
   // R6: byte strobe lines up with a rising serial clock
   a_r6_vld_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld_o |-> (sclk_o && !$past(sclk_o)));
   // R9: chip select held low while the clock runs
   a_r9_cs_low_active: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> !cs_n_o);
   // R9: finished loader is deselected with a parked clock
   a_r9_done_parked: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cs_n_o && !sclk_o));
   // R10: done never drops before reset
   a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);
endmodule

// File: tb/sim_cfg_flash_loader.sv
module sim_cfg_flash_loader;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 4;
   // fields: [21:19] mode, [18:16] variant, [15:8] byte count, [7:0] first byte
   localparam logic [21:0] VEC [NV] = '{
      {3'b001, 3'b111, 8'd3, 8'hF0},
      {3'b001, 3'b000, 8'd4, 8'h5D},
      {3'b001, 3'b111, 8'd3, 8'h82},
      {3'b001, 3'b010, 8'd5, 8'h27}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_i = 1'b0;
   logic [2:0]  mode_i = 3'b000;
   logic [2:0]  variant_i = 3'b000;
   logic [15:0] byte_count_i = 16'd0;
   logic        cs_n_o, sclk_o, mosi_o;
   logic        din_i = 1'b0;
   logic [7:0]  data_o;
   logic        data_vld_o, done_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cfg_flash_loader u0 (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .mode_i(mode_i),
      .variant_i(variant_i), .byte_count_i(byte_count_i), .cs_n_o(cs_n_o),
      .sclk_o(sclk_o), .mosi_o(mosi_o), .din_i(din_i), .data_o(data_o),
      .data_vld_o(data_vld_o), .done_o(done_o)
   );

   // cycle counter
   int cyc = 0;
   always @(posedge clk) cyc++;

   // flash model
   int          hdr_len_exp = 40;
   logic [7:0]  fbytes [8];
   int          rcnt = 0;
   logic [39:0] hdr_cap = '0;
   int          rise_prev = 0, per_first = 0, per_last = 0;
   logic        sclk_prev = 1'b0, cs_prev = 1'b1;

   always @(sclk_o or cs_n_o) begin
      if (cs_prev && !cs_n_o) begin
         rcnt = 0;
         hdr_cap = '0;
         din_i = 1'b0;
         rise_prev = cyc;
         per_first = 0;
         per_last = 0;
      end else if (!cs_n_o && sclk_o && !sclk_prev) begin
         if (rcnt < hdr_len_exp) hdr_cap = {hdr_cap[38:0], mosi_o};
         rcnt++;
         if (rcnt == 2) per_first = cyc - rise_prev;
         per_last = cyc - rise_prev;
         rise_prev = cyc;
      end else if (!cs_n_o && !sclk_o && sclk_prev && rcnt >= hdr_len_exp) begin
         int d;
         d = rcnt - hdr_len_exp;
         din_i = (d / 8 < 8) ? fbytes[d / 8][7 - (d % 8)] : 1'b0;
      end
      sclk_prev = sclk_o;
      cs_prev = cs_n_o;
   end

   // received bytes
   logic [7:0] rx_mem [64];
   int rx_n = 0;
   always @(negedge clk) begin
      if (data_vld_o) begin
         if (rx_n < 64) rx_mem[rx_n] = data_o;
         rx_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int div_of(input logic [1:0] f);
      case (f)
         2'b00: return 64;
         2'b01: return 16;
         2'b10: return 8;
         default: return 4;
      endcase
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      init_i = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic set_image(input logic [7:0] first, input logic [2:0] v);
      fbytes[0] = first;
      for (int k = 1; k < 8; k++) fbytes[k] = 8'h3C + 8'(k * 41);
      hdr_len_exp = (v == 3'b111) ? 40 : 32;
   endtask

   task automatic start_load(input logic [2:0] m, input logic [2:0] v, input logic [15:0] c);
      @(negedge clk);
      mode_i = m;
      variant_i = v;
      byte_count_i = c;
      init_i = 1'b0;
      repeat (3) @(negedge clk);
      init_i = 1'b1;
   endtask

   task automatic wait_done(input int lim, output bit ok);
      ok = 0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (done_o) begin
            ok = 1;
            break;
         end
      end
   endtask

   function automatic logic [39:0] hdr_exp(input logic [2:0] v);
      return (v == 3'b111) ? {8'h0B, 32'h0} : {8'h00, 8'h03, 24'h0};
   endfunction

   task automatic check_load(input logic [2:0] v, input int cnt, input logic [7:0] first,
                             input int base, input bit ok);
      int nb;
      nb = (cnt == 0) ? 1 : cnt;
      chk(ok, "R9", "done raised", 64'(ok), 64'd1);
      chk(hdr_cap == hdr_exp(v), "R3", "header bits msb first (R4)", 64'(hdr_cap), 64'(hdr_exp(v)));
      chk(rx_n - base == nb, "R6", "one strobe per byte", 64'(rx_n - base), 64'(nb));
      for (int k = 0; k < nb; k++)
         chk(rx_mem[base + k] == fbytes[k], "R5", "received byte", 64'(rx_mem[base + k]), 64'(fbytes[k]));
      chk(per_first == 64, "R7", "initial sclk period", 64'(per_first), 64'd64);
      if (nb > 1)
         chk(per_last == div_of(first[1:0]), "R8", "switched sclk period",
             64'(per_last), 64'(div_of(first[1:0])));
      chk(cs_n_o && !sclk_o, "R9", "deselected and parked after load",
          64'({cs_n_o, sclk_o}), 64'b10);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R9 watchdog expired: actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit ok;
      int base;
      int bad;

      // reset state (R1)
      do_reset();
      chk(cs_n_o == 1'b1, "R1", "reset cs_n", 64'(cs_n_o), 64'd1);
      chk(sclk_o == 1'b0, "R1", "reset sclk", 64'(sclk_o), 64'd0);
      chk(done_o == 1'b0 && data_vld_o == 1'b0, "R1", "reset done/vld",
          64'({done_o, data_vld_o}), 64'd0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         do_reset();
         set_image(VEC[i][7:0], VEC[i][18:16]);
         base = rx_n;
         start_load(VEC[i][21:19], VEC[i][18:16], 16'(VEC[i][15:8]));
         @(negedge clk);
         chk(cs_n_o == 1'b0, "R1", "cs_n low one clock after init rise", 64'(cs_n_o), 64'd0);
         wait_done(20000, ok);
         check_load(VEC[i][18:16], int'(VEC[i][15:8]), VEC[i][7:0], base, ok);
      end

      // R1: non-serial mode stays idle, then a new init edge is sampled
      do_reset();
      set_image(8'h01, 3'b000);
      start_load(3'b011, 3'b000, 16'd2);
      bad = 0;
      repeat (300) begin
         @(negedge clk);
         if (!cs_n_o || sclk_o) bad++;
      end
      chk(bad == 0, "R1", "non-serial mode idle cycles", 64'(bad), 64'd0);
      base = rx_n;
      start_load(3'b001, 3'b000, 16'd2);
      wait_done(20000, ok);
      chk(ok && (rx_n - base == 2), "R1", "later init edge starts load", 64'(rx_n - base), 64'd2);

      // R2: strap and count changes during the load are ignored
      do_reset();
      set_image(8'h01, 3'b000);
      base = rx_n;
      start_load(3'b001, 3'b000, 16'd2);
      repeat (500) @(negedge clk);
      mode_i = 3'b000;
      variant_i = 3'b111;
      byte_count_i = 16'd9;
      init_i = 1'b0;
      repeat (20) @(negedge clk);
      init_i = 1'b1;
      wait_done(20000, ok);
      chk(hdr_cap == hdr_exp(3'b000), "R2", "header unchanged by strap change",
          64'(hdr_cap), 64'(hdr_exp(3'b000)));
      chk(rx_n - base == 2, "R2", "byte count unchanged", 64'(rx_n - base), 64'd2);
      chk(ok, "R2", "load completes", 64'(ok), 64'd1);

      // R9: count of zero reads one byte
      do_reset();
      set_image(8'h03, 3'b111);
      base = rx_n;
      start_load(3'b001, 3'b111, 16'd0);
      wait_done(20000, ok);
      check_load(3'b111, 0, 8'h03, base, ok);

      // R10: done sticky, later init edges ignored
      start_load(3'b001, 3'b000, 16'd1);
      bad = 0;
      repeat (300) begin
         @(negedge clk);
         if (!done_o || !cs_n_o || sclk_o) bad++;
      end
      chk(bad == 0, "R10", "done holds and no restart", 64'(bad), 64'd0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule